// File: doc/BRIEF.md
# Multiprocessor Limit Timer Array

This block holds one private interval timer for each processor in a cluster, plus one master timer that all of them share. Software reaches every timer through a small 32-bit register bus. Each timer keeps a 21-bit limit and a 21-bit running count.

A common tick enable advances every count at the same moment. When a count reaches its limit, it restarts from zero and raises a sticky limit flag. While that flag is set, the timer drives an interrupt level. A private timer drives only its own processor's level-14 line. The master timer drives the level-10 line of every processor at once.

Software acknowledges a timer by reading its limit register. A second limit port, which never clears anything, lets software retune the period without disturbing a count that is in progress.

Top module: `mp_limit_timers`

## Requirements
- R1: After reset, every private timer's limit register reads 0x009C4000, the master limit reads 0x00000000, all counts read 0 and all interrupt outputs are low.
- R2: The word address is {timer index, register select}, with the register select in the low two bits. Select 0 is the limit register, select 1 the count register and select 2 the write-only no-clear limit port. Select 3 is reserved. Index NUM_CPU is the master timer. A read of select 2, select 3 or an index above NUM_CPU returns 0. Read data appears on `bus_rdata` one cycle after the read strobe.
- R3: In a limit or count word, bit 31 is the limit flag, bits 30:10 hold the 21-bit field and bits 9:0 read as 0. Each cycle with `tick_en` high adds one to the count. When the incremented count equals the limit, the count becomes 0 and the flag sets.
- R4: A read of the limit register returns the flag as it was before the read, then clears the flag, unless a wrap happens in the same cycle.
- R5: A read of the count register changes neither the count nor the flag.
- R6: A write to the limit register stores bits 30:10 as the new limit and clears both the count and the flag.
- R7: A write to the no-clear port stores bits 30:10 as the new limit and leaves the count and flag unchanged.
- R8: A limit field of 0 gives the full 2^21-tick period. The count runs past every nonzero value and wraps only after all ones.
- R9: `irq_l14[i]` is high exactly when private timer i's flag was set one cycle earlier, and no other private timer affects it.
- R10: Every bit of `irq_l10` equals the master flag as it was one cycle earlier.
- R11: Write data bits 31 and 9:0 have no effect on any timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable shared by all timers |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address {index, select} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_l14 | output | NUM_CPU | Private timer interrupt levels, one per processor |
| irq_l10 | output | NUM_CPU | Master timer interrupt level, copied to every processor |

## Verification
The hardest state to reach from the ports is the full-range case of a zero limit, because a real wrap would take two million ticks. The bench gets there with a period of eight. It runs the count to seven, switches the limit to zero through the no-clear port, and ticks once more. A count that reaches eight with no flag shows that zero is not being compared literally.

All timers share one tick, so other timers keep counting during every test. Each test therefore restores its timer to a zero limit, which keeps stray flags off the interrupt vectors.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int FIELD_W   = 21;
  localparam int FIELD_LSB = 10;
  localparam int WORD_W    = 32;

  typedef enum logic [1:0] {
    SEL_LIMIT = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_NOCLR = 2'd2,
    SEL_RSVD  = 2'd3
  } lt_sel_e;

  function automatic logic [WORD_W-1:0] pack_word(input logic flag,
                                                  input logic [FIELD_W-1:0] fld);
    return {flag, fld, {FIELD_LSB{1'b0}}};
  endfunction

  function automatic logic [FIELD_W-1:0] take_field(input logic [WORD_W-1:0] w);
    return w[FIELD_LSB +: FIELD_W];
  endfunction
endpackage

// File: rtl/lt_bus_decode.sv
module lt_bus_decode
  import lt_pkg::*;
#(
  parameter int NUM_T = 5,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [IDX_W+1:0] addr,
  output logic [NUM_T-1:0] wr_lim,
  output logic [NUM_T-1:0] wr_nc,
  output logic [NUM_T-1:0] rd_lim
);
  logic [IDX_W-1:0] idx;
  lt_sel_e          sel;

  assign idx = addr[IDX_W+1:2];
  assign sel = lt_sel_e'(addr[1:0]);

  for (genvar t = 0; t < NUM_T; t++) begin : g_dec
    logic hit;
    assign hit       = (idx == IDX_W'(t));
    assign wr_lim[t] = wr && hit && (sel == SEL_LIMIT);
    assign wr_nc[t]  = wr && hit && (sel == SEL_NOCLR);
    assign rd_lim[t] = rd && hit && (sel == SEL_LIMIT);
  end

  // R2: an access touches at most one timer
  p_one_target_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_lim | wr_nc | rd_lim));
endmodule

// File: rtl/lt_timer_unit.sv
module lt_timer_unit
  import lt_pkg::*;
#(
  parameter logic [FIELD_W-1:0] RESET_LIMIT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               wr_lim,
  input  logic               wr_nc,
  input  logic               rd_lim,
  input  logic [FIELD_W-1:0] wfield,
  output logic [FIELD_W-1:0] lim_q,
  output logic [FIELD_W-1:0] cnt_q,
  output logic               flag_q
);
  logic [FIELD_W-1:0] cnt_inc;
  logic               at_end;
  logic               wrap;

  assign cnt_inc = cnt_q + FIELD_W'(1);
  // a zero limit stands for the full field range
  assign at_end  = (lim_q == '0) ? (cnt_q == '1) : (cnt_inc == lim_q);
  assign wrap    = tick && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q  <= RESET_LIMIT;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (wr_lim) begin
      lim_q  <= wfield;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_nc) lim_q <= wfield;
      if (tick)  cnt_q <= wrap ? '0 : cnt_inc;
      if (wrap)        flag_q <= 1'b1;
      else if (rd_lim) flag_q <= 1'b0;
    end
  end

  p_wrap_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (wrap && !wr_lim) |=> (flag_q && cnt_q == '0));
  p_tick_counts_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !wrap && !wr_lim) |=> (cnt_q == $past(cnt_q) + FIELD_W'(1)));
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_lim && !wrap && !wr_lim) |=> !flag_q);
  p_idle_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_lim && !rd_lim) |=> ($stable(cnt_q) && $stable(flag_q)));
  p_write_clears_r6: assert property (@(posedge clk) disable iff (rst)
    wr_lim |=> (cnt_q == '0 && !flag_q && lim_q == $past(wfield)));
  p_noclear_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_nc && !wr_lim && !tick && !rd_lim) |=>
      ($stable(cnt_q) && $stable(flag_q) && lim_q == $past(wfield)));
endmodule

// File: rtl/lt_read_mux.sv
module lt_read_mux
  import lt_pkg::*;
#(
  parameter int NUM_T = 5,
  parameter int IDX_W = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rd,
  input  logic [IDX_W+1:0]                addr,
  input  logic [NUM_T-1:0][FIELD_W-1:0]   lim_all,
  input  logic [NUM_T-1:0][FIELD_W-1:0]   cnt_all,
  input  logic [NUM_T-1:0]                flag_all,
  output logic [WORD_W-1:0]               rdata
);
  logic [IDX_W-1:0]  idx;
  lt_sel_e           sel;
  logic [WORD_W-1:0] word_nx;

  assign idx = addr[IDX_W+1:2];
  assign sel = lt_sel_e'(addr[1:0]);

  always_comb begin
    word_nx = '0;
    for (int t = 0; t < NUM_T; t++) begin
      if (idx == IDX_W'(t)) begin
        case (sel)
          SEL_LIMIT: word_nx = pack_word(flag_all[t], lim_all[t]);
          SEL_COUNT: word_nx = pack_word(flag_all[t], cnt_all[t]);
          default:   word_nx = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= word_nx;
  end

  p_wo_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd && addr[1]) |=> (rdata == '0));
  p_low_bits_zero_r3: assert property (@(posedge clk) disable iff (rst)
    rdata[FIELD_LSB-1:0] == '0);
endmodule

// File: rtl/mp_limit_timers.sv
module mp_limit_timers
  import lt_pkg::*;
#(
  parameter int               NUM_CPU          = 4,
  parameter logic [31:0]      CPU_RESET_WORD   = 32'h009C_4000,
  parameter logic [31:0]      MASTER_RESET_WORD = 32'h0000_0000,
  localparam int              NUM_T            = NUM_CPU + 1,
  localparam int              IDX_W            = $clog2(NUM_T),
  localparam int              ADDR_W           = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CPU-1:0] irq_l14,
  output logic [NUM_CPU-1:0] irq_l10
);
  logic [NUM_T-1:0]              wr_lim, wr_nc, rd_lim;
  logic [NUM_T-1:0][FIELD_W-1:0] lim_all, cnt_all;
  logic [NUM_T-1:0]              flag_all;
  logic [FIELD_W-1:0]            wfield;

  assign wfield = take_field(bus_wdata);

  lt_bus_decode #(.NUM_T(NUM_T), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wr_lim(wr_lim), .wr_nc(wr_nc), .rd_lim(rd_lim)
  );

  for (genvar t = 0; t < NUM_T; t++) begin : g_tmr
    localparam logic [31:0] RW = (t < NUM_CPU) ? CPU_RESET_WORD : MASTER_RESET_WORD;
    lt_timer_unit #(.RESET_LIMIT(RW[FIELD_LSB +: FIELD_W])) u_tmr (
      .clk(clk), .rst(rst), .tick(tick_en),
      .wr_lim(wr_lim[t]), .wr_nc(wr_nc[t]), .rd_lim(rd_lim[t]),
      .wfield(wfield),
      .lim_q(lim_all[t]), .cnt_q(cnt_all[t]), .flag_q(flag_all[t])
    );
  end

  lt_read_mux #(.NUM_T(NUM_T), .IDX_W(IDX_W)) u_rmux (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr),
    .lim_all(lim_all), .cnt_all(cnt_all), .flag_all(flag_all),
    .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_l14 <= '0;
      irq_l10 <= '0;
    end else begin
      irq_l14 <= flag_all[NUM_CPU-1:0];
      irq_l10 <= {NUM_CPU{flag_all[NUM_CPU]}};
    end
  end

  p_private_irq_r9: assert property (@(posedge clk) disable iff (rst)
    irq_l14 == $past(flag_all[NUM_CPU-1:0]));
  p_master_bcast_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_l10 == '0) || (irq_l10 == '1));
  p_master_follows_r10: assert property (@(posedge clk) disable iff (rst)
    irq_l10[0] == $past(flag_all[NUM_CPU]));
endmodule

// File: tb/tb_mp_limit_timers.sv
module tb_mp_limit_timers;
  localparam int NC = 4;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic          tick_en, bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NC-1:0] irq_l14, irq_l10;
  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  mp_limit_timers #(.NUM_CPU(NC)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_l14(irq_l14), .irq_l10(irq_l10)
  );

  function automatic logic [AW-1:0] adr(input int idx, input int sel);
    return {3'(idx), 2'(sel)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int sel, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = adr(idx, sel); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int idx, input int sel, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = adr(idx, sel);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq14", 32'(irq_l14), 0);
    chk("R1 irq10", 32'(irq_l10), 0);
    rd(0, 0, d); chk("R1 cpu0 limit", d, 32'h009C_4000);
    rd(3, 0, d); chk("R1 cpu3 limit", d, 32'h009C_4000);
    rd(4, 0, d); chk("R1 master limit", d, 32'h0);
    rd(2, 1, d); chk("R1 count", d, 32'h0);
  endtask

  task automatic t_count_wrap();
    logic [31:0] d;
    wr(1, 0, 32'h8000_17FF);      // field 5, stray bits set
    rd(1, 0, d); chk("R11 ignored bits", d, 32'h0000_1400);
    ticks(3);
    rd(1, 1, d); chk("R3 count 3", d, 32'h0000_0C00);
    rd(1, 1, d); chk("R5 count read no effect", d, 32'h0000_0C00);
    ticks(2);
    @(negedge clk);
    chk("R9 irq14 own cpu", 32'(irq_l14), 32'h2);
    chk("R10 irq10 idle", 32'(irq_l10), 0);
    rd(1, 1, d); chk("R3 wrap sets flag", d, 32'h8000_0000);
    chk("R5 flag kept after count read", 32'(irq_l14), 32'h2);
    rd(1, 0, d); chk("R4 limit read sees flag", d, 32'h8000_1400);
    @(negedge clk);
    chk("R4 irq cleared", 32'(irq_l14), 0);
    rd(1, 1, d); chk("R4 flag cleared", d, 32'h0);
    wr(1, 0, 32'h0);
  endtask

  task automatic t_noclear();
    logic [31:0] d;
    wr(2, 0, 32'h0000_2800);      // limit 10
    ticks(4);
    wr(2, 2, 32'h0000_1800);      // limit 6, keep count
    rd(2, 1, d); chk("R7 count kept", d, 32'h0000_1000);
    rd(2, 2, d); chk("R2 noclear reads zero", d, 32'h0);
    rd(2, 3, d); chk("R2 reserved reads zero", d, 32'h0);
    ticks(2);
    rd(2, 1, d); chk("R7 new limit used", d, 32'h8000_0000);
    wr(2, 0, 32'h0000_2800);
    rd(2, 1, d); chk("R6 write clears flag", d, 32'h0);
    @(negedge clk);
    chk("R6 irq low", 32'(irq_l14), 0);
    wr(2, 0, 32'h0);
  endtask

  task automatic t_master();
    logic [31:0] d;
    wr(4, 0, 32'h0000_0C00);      // limit 3
    ticks(3);
    @(negedge clk);
    chk("R10 irq10 broadcast", 32'(irq_l10), 32'hF);
    chk("R9 no private irq", 32'(irq_l14), 0);
    rd(4, 0, d); chk("R4 master ack", d, 32'h8000_0C00);
    @(negedge clk);
    chk("R10 irq10 cleared", 32'(irq_l10), 0);
    wr(4, 0, 32'h0);
  endtask

  task automatic t_zero_limit();
    logic [31:0] d;
    wr(3, 0, 32'h0000_2000);      // limit 8
    ticks(7);
    rd(3, 1, d); chk("R8 count 7", d, 32'h0000_1C00);
    wr(3, 2, 32'h0);              // zero limit: full range
    ticks(1);
    rd(3, 1, d); chk("R8 passes old limit", d, 32'h0000_2000);
    rd(3, 0, d); chk("R8 limit zero", d, 32'h0);
    rd(5, 0, d); chk("R2 index beyond master", d, 32'h0);
  endtask

  initial begin
    rst = 1'b1; tick_en = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count_wrap();
    t_noclear();
    t_master();
    t_zero_limit();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule